// File: doc/BRIEF.md
# Base-Complement Unsigned Multiplier

This block multiplies two unsigned W-bit operands. It uses the base-complement method around the power-of-two base 2^W. Each operand is turned into its distance below the base, called its deviation. A coarse term is formed by taking one operand and subtracting the deviation of the other. A fine term is the product of the two deviations. The product is the coarse term shifted up by W bits plus the fine term. The method pays off when both operands sit near the top of their range, because the deviations are then small.

A caller raises `start` for one cycle while the block is idle. The block captures both operands on that edge. An iterative shift-add unit then forms the deviation product, and a signed merge stage builds the final value. The product is registered and flagged by a one-cycle `done` pulse. `busy` stays high from the cycle after the accepted `start` until `done` is raised.

Top module: `basecomp_mul`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `product` is 0, `done` is 0 and `busy` is 0.
- R2: A `start` sampled high while `busy` is low is accepted: `busy` reads 1 after that clock edge.
- R3: For every pair of W-bit operands, including 0 and 2^W-1, `product` equals op_a×op_b exactly in 2W bits.
- R4: `done` is a single-cycle pulse. It is set by the (W+3)-th clock edge after the edge that accepted `start`, and `busy` clears on that same edge.
- R5: A `start` sampled while `busy` is high is ignored, and the result belongs to the operands that were accepted earlier.
- R6: The operands are sampled only on the accepting edge. Later changes on `op_a`/`op_b` do not alter the result.
- R7: `product` keeps its value except on the edge that raises `done`.
- R8: Each deviation equals 2^W minus its operand and is held in W+1 bits. The coarse term op_a − dev_b equals op_b − dev_a.
- R9: The fine term equals dev_a×dev_b and is produced by a shift-add unit that runs W+1 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication; honoured only when idle |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: `product` has just been updated |
| product | output | 2W | Registered unsigned product |

## Verification
The result is due on the (W+3)-th edge after the edge that accepts `start`. `busy` is due on the very next edge. The driver stamps each accepted request with the current edge count, and the monitor checks the stamp when it sees `done` at a falling edge. With W = 8 this is 12 edges from the falling edge at which `start` was driven. On every falling edge without `done`, the monitor also checks that `product` is unchanged. Operands are scrambled straight after acceptance, and extra `start` pulses are injected mid-run, so the scoreboard entry stays tied to the captured pair. The sweep covers all 256 values of op_a, each against corner and data-dependent values of op_b, with 0 and 2^W−1 on both sides.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  // Sequencer states of the multiplier controller
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LAUNCH,
    SEQ_ITER
  } seq_state_t;

endpackage

// File: rtl/bcm_deviation.sv
// Distance of an operand below the base 2^W, held in W+1 bits so that an
// operand of zero yields exactly 2^W.
module bcm_deviation #(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd,
  output logic [W:0]   dev
);

  localparam logic [W:0] BASE = {1'b1, {W{1'b0}}};

  always_comb begin
    dev = BASE - {1'b0, opnd};
  end

endmodule

// File: rtl/bcm_shiftadd.sv
// Iterative unsigned multiplier: one multiplier bit per cycle.
module bcm_shiftadd #(
  parameter int XW = 9,
  parameter int PW = 2 * XW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [XW-1:0] x,
  input  logic [XW-1:0] y,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] prod
);

  localparam int CW = $clog2(XW + 1);

  logic [PW-1:0] mcand;
  logic [XW-1:0] mplier;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      prod   <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        prod   <= '0;
        mcand  <= PW'(x);
        mplier <= y;
        cnt    <= CW'(XW);
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) begin
          prod <= prod + mcand;
        end
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0)); // R9

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy); // R5

  AST_ITER_SPAN: assert property (@(posedge clk) disable iff (rst)
    go |=> busy); // R9

endmodule

// File: rtl/bcm_merge.sv
// Signed combination: coarse term shifted by W plus the deviation product.
module bcm_merge #(
  parameter int W = 8
) (
  input  logic [W-1:0]        opnd,
  input  logic [W:0]          dev_other,
  input  logic [2*W+1:0]      fine,
  output logic signed [W+1:0] coarse,
  output logic [2*W+1:0]      full
);

  localparam int FW = 2 * W + 2;

  logic [FW-1:0] shifted;

  always_comb begin
    coarse  = $signed({2'b00, opnd}) - $signed({1'b0, dev_other});
    shifted = {coarse, {W{1'b0}}};
    full    = shifted + fine;
  end

endmodule

// File: rtl/basecomp_mul.sv
module basecomp_mul
  import bcm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);

  localparam int DW = W + 1;
  localparam int PW = 2 * DW;
  localparam logic [W+1:0] BASE_EXT = (W + 2)'(1) << W;

  seq_state_t state;

  logic [W-1:0]        a_q;
  logic [W-1:0]        b_q;
  logic [DW-1:0]       dev_a;
  logic [DW-1:0]       dev_b;
  logic                mul_go;
  logic                mul_busy;
  logic                mul_done;
  logic [PW-1:0]       mul_prod;
  logic signed [W+1:0] coarse;
  logic [PW-1:0]       merged;

  bcm_deviation #(.W(W)) u_dev_a (.opnd(a_q), .dev(dev_a));
  bcm_deviation #(.W(W)) u_dev_b (.opnd(b_q), .dev(dev_b));

  assign mul_go = (state == SEQ_LAUNCH);

  bcm_shiftadd #(.XW(DW), .PW(PW)) u_fine (
    .clk  (clk),
    .rst  (rst),
    .go   (mul_go),
    .x    (dev_a),
    .y    (dev_b),
    .busy (mul_busy),
    .done (mul_done),
    .prod (mul_prod)
  );

  bcm_merge #(.W(W)) u_merge (
    .opnd      (a_q),
    .dev_other (dev_b),
    .fine      (mul_prod),
    .coarse    (coarse),
    .full      (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            a_q   <= op_a;
            b_q   <= op_b;
            busy  <= 1'b1;
            state <= SEQ_LAUNCH;
          end
        end
        SEQ_LAUNCH: begin
          state <= SEQ_ITER;
        end
        SEQ_ITER: begin
          if (mul_done) begin
            product <= merged[2*W-1:0];
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Alternative cross-subtraction, used only by the checks below
  logic signed [W+1:0] coarse_alt;
  assign coarse_alt = $signed({2'b00, b_q}) - $signed({1'b0, dev_a});

  AST_CROSS_EQUAL: assert property (@(posedge clk) disable iff (rst)
    busy |-> (coarse == coarse_alt)); // R8

  AST_DEV_SUM: assert property (@(posedge clk) disable iff (rst)
    busy |-> (({1'b0, dev_a} + {2'b00, a_q}) == BASE_EXT)); // R8

  AST_FINE_TERM: assert property (@(posedge clk) disable iff (rst)
    mul_done |-> (mul_prod == (PW'(dev_a) * PW'(dev_b)))); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    mul_done |-> (merged[PW-1:2*W] == 2'b00)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(a_q) && $stable(b_q))); // R5

  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done); // R7

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R4

endmodule

// File: tb/test_basecomp_mul.sv
`timescale 1ns/1ps
module test_basecomp_mul;

  localparam int W         = 8;
  // Edges counted from the falling edge that drives start to the falling
  // edge that sees done: one to accept, then W+3 to the result.
  localparam int LAT_EDGES = W + 4;
  localparam int WD_LIMIT  = 190000;

  typedef struct {
    logic [W-1:0]   a;
    logic [W-1:0]   b;
    logic [2*W-1:0] p;
    int             t;
  } item_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  item_t          sb[$];
  int             cyc = 0;
  int             checks = 0;
  int             errors = 0;
  bit             run = 1'b0;
  bit             prev_done = 1'b0;
  logic [2*W-1:0] last_prod = '0;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  basecomp_mul #(.W(W)) i_basecomp_mul (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (run) begin
      if (done) begin
        chk(!prev_done, "R4", "done longer than one cycle", 1, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R5", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(product == it.p, "R3", $sformatf("product %0d*%0d", it.a, it.b),
              product, it.p);
          chk(cyc - it.t == LAT_EDGES, "R4", "latency", cyc - it.t, LAT_EDGES);
          chk(!busy, "R4", "busy with done", busy, 0);
        end
        last_prod = product;
      end else begin
        chk(product == last_prod, "R7", "product held", product, last_prod);
      end
      prev_done = done;
    end
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit intrude);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    it.a = a;
    it.b = b;
    it.p = (2*W)'(a) * (2*W)'(b);
    it.t = cyc;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    op_a  = ~a;          // R6: scramble after acceptance
    op_b  = b + 8'd1;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    if (intrude) begin
      @(negedge clk);
      @(negedge clk);
      start = 1'b1;      // R5: start while busy must be ignored
      op_a  = a ^ 8'hA5;
      op_b  = 8'h3C;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  function automatic logic [W-1:0] pick_b(input logic [W-1:0] a, input int k);
    case (k)
      0:  return '0;
      1:  return W'(1);
      2:  return W'(8'h7F);
      3:  return W'(8'h80);
      4:  return W'(8'hFE);
      5:  return W'(8'hFF);
      6:  return a;
      7:  return ~a;
      8:  return a ^ W'(8'h55);
      9:  return a + W'(1);
      10: return a - W'(3);
      default: return W'(a * W'(37) + W'(11));
    endcase
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog: cycles=%0d expected below %0d", cyc, WD_LIMIT);
    finish_run();
  end

  initial begin
    start = 1'b1;        // must not matter under reset
    repeat (3) @(negedge clk);
    chk(product == '0, "R1", "product in reset", product, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    start = 1'b0;
    rst   = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && product == '0, "R1",
        "idle after reset", {busy, done}, 0);
    run = 1'b1;

    // Corners (R3): zero gives deviation 2^W, top value deviation 1
    issue(8'd0,   8'd0,   1'b0);
    issue(8'd0,   8'd255, 1'b0);
    issue(8'd255, 8'd0,   1'b0);
    issue(8'd255, 8'd255, 1'b0);
    issue(8'd128, 8'd128, 1'b0);
    issue(8'd255, 8'd1,   1'b0);
    issue(8'd250, 8'd247, 1'b0);

    // Start pulses during a run (R5) with scrambled operands (R6)
    issue(8'd200, 8'd199, 1'b1);
    issue(8'd0,   8'd37,  1'b1);
    issue(8'd17,  8'd255, 1'b1);

    // Sweep: every op_a against corner and data-dependent op_b (R3, R8, R9)
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 12; k++) begin
        issue(W'(a), pick_b(W'(a), k), 1'b0);
      end
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    chk(busy == 1'b0, "R4", "idle at end", busy, 0);
    finish_run();
  end

endmodule